// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns bytes written by a processor into a serial bit stream on one output line. A byte is written into a holding register; as soon as the serial path is free, the byte is copied into an internal shift register that software cannot reach, and the holding register is reported empty again so the next byte can be written while the current one is still going out. Bits leave least significant first. Every bit is held on the line for a fixed number of bit-clock enable ticks. The ticks come from an external rate generator.

A separate mode register sets the framing. In the asynchronous mode a frame is a low start bit, seven or eight data bits, an optional even or odd parity bit and one or two high stop bits. In the clocked synchronous mode exactly eight data bits are sent with no framing bits. The block also drives a serial clock that is low during the first half of each bit and high for the second half, so a receiver can sample on the rising edge. A multiprocessor-format selection removes the parity bit. The format is captured when a frame starts, so rewriting the mode register in the middle of a frame changes only later frames.

Top module: `sfx_tx`

## Requirements
- R1: After reset, txd and sclk are high, dre is 1 (holding register empty) and tend is 1. The mode register resets to all zeros, which is asynchronous mode with 8 data bits, no parity and 1 stop bit.
- R2: A data write clears dre in the next cycle. When the transmitter is idle, the held byte moves into the shift register one cycle after the write, dre returns to 1 and the first bit appears on txd in that same cycle.
- R3: Mode register layout: bit 7 selects clocked synchronous mode (1) or asynchronous mode (0), bit 6 selects 7 data bits, bit 5 enables parity, bit 4 selects odd parity, bit 3 selects two stop bits, bit 2 selects multiprocessor format, and bits 1:0 are unused. An asynchronous frame is a 0 start bit followed by the data bits LSB first, and each bit lasts ASYNC_TICKS ticks (default 16).
- R4: With bit 6 set in asynchronous mode, only data bits 6:0 are sent and bit 7 of the written byte is dropped. Parity then covers those 7 bits.
- R5: With parity enabled in asynchronous mode, one parity bit follows the data. The bit gives an even count of ones over data and parity when bit 4 is 0, and an odd count when bit 4 is 1.
- R6: When multiprocessor format is selected, no parity bit is sent, whatever the parity-enable bit says.
- R7: A frame ends with one stop bit at 1, or two stop bits at 1 when bit 3 is set.
- R8: In clocked synchronous mode exactly 8 data bits are sent LSB first, each lasting SYNC_TICKS ticks (default 2). No start, parity or stop bit is sent, whatever bits 6, 5 and 3 say. sclk is low for the first SYNC_TICKS/2 ticks of each bit and high otherwise, including while idle.
- R9: tend goes to 1 in the cycle after the last bit time of a frame if no byte is pending, and goes to 0 when a frame is loaded. If a byte is pending, the next frame starts in that same cycle with no idle gap.
- R10: If a data write falls in the cycle in which the held byte is loaded, the old byte is transmitted, the new byte stays held and dre stays 0.
- R11: The frame format is taken from the mode register at the moment of loading. A mode write during a frame affects only later frames.
- R12: While a frame is in progress, txd changes only on a cycle that carries a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | DATA_W | Mode register write value |
| data_wr | input | 1 | Write strobe for the holding register |
| data_wdata | input | DATA_W | Byte to transmit |
| tick | input | 1 | Bit-clock enable from the rate generator |
| txd | output | 1 | Serial data line, idles high |
| sclk | output | 1 | Serial clock used in synchronous mode, idles high |
| dre | output | 1 | Holding register empty |
| tend | output | 1 | Transmission ended, nothing pending |

## Verification
Two pairs of events can fall in the same cycle. A processor write can land in the cycle in which the held byte is taken into the shift register, and the end of one frame can land in the cycle in which the next frame loads. The first pair is provoked by two data writes on consecutive cycles while the line is idle. The second is provoked by writing a new byte in the middle of a running frame, so that the frame ends with a byte pending. A behavioural reference model, made of a bit queue and counters, predicts txd, sclk, dre and tend for every cycle. The bench compares all four outputs against it, which shows whether the right byte was sent, whether the empty flag stayed clear and whether any idle bit slipped in between the frames.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  // Bit positions inside the mode register
  localparam int MB_SYNC  = 7;
  localparam int MB_CHR7  = 6;
  localparam int MB_PEN   = 5;
  localparam int MB_ODD   = 4;
  localparam int MB_STOP2 = 3;
  localparam int MB_MP    = 2;

  typedef struct packed {
    logic sync;
    logic chr7;
    logic par_en;
    logic par_odd;
    logic stop2;
    logic mp;
  } mode_t;
endpackage

// File: rtl/sfx_mode_reg.sv
module sfx_mode_reg
  import sfx_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output mode_t            mode_o
);
  mode_t mode_q;
  logic  unused_bits;

  assign unused_bits = ^wdata[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (wr) begin
      mode_q.sync    <= wdata[MB_SYNC];
      mode_q.chr7    <= wdata[MB_CHR7];
      mode_q.par_en  <= wdata[MB_PEN];
      mode_q.par_odd <= wdata[MB_ODD];
      mode_q.stop2   <= wdata[MB_STOP2];
      mode_q.mp      <= wdata[MB_MP];
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/sfx_hold.sv
module sfx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              dre_o
);
  logic [DATA_W-1:0] data_q;
  logic              full_q;

  // A write in the cycle of a take wins: the new byte stays held.
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (wr) begin
      data_q <= wdata;
      full_q <= 1'b1;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign dre_o  = ~full_q;

  // R2: a write always leaves the holding register full
  a_r2_write_fills: assert property (@(posedge clk) disable iff (rst)
    wr |=> full_q);
  // R2: the shifter only takes a byte that is there
  a_r2_take_needs_byte: assert property (@(posedge clk) disable iff (rst)
    take |-> full_q);
  // R10: write colliding with a take keeps the new byte held
  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    (wr && take) |=> (full_q && data_q == $past(wdata)));
endmodule

// File: rtl/sfx_frame_build.sv
module sfx_frame_build
  import sfx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int LEN_W   = 4
) (
  input  logic [DATA_W-1:0]  data_i,
  input  mode_t              mode_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [LEN_W-1:0]   len_o
);
  logic              narrow;
  logic              par_on;
  logic              par_bit;
  logic [DATA_W-1:0] dmask;
  int                nbits;

  assign narrow = ~mode_i.sync & mode_i.chr7;
  assign par_on = ~mode_i.sync & mode_i.par_en & ~mode_i.mp;
  assign nbits  = narrow ? DATA_W - 1 : DATA_W;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i == DATA_W - 1) begin : g_top
      assign dmask[i] = data_i[i] & ~narrow;
    end else begin : g_low
      assign dmask[i] = data_i[i];
    end
  end

  assign par_bit = (^dmask) ^ mode_i.par_odd;

  always_comb begin
    frame_o = '1;
    if (mode_i.sync) begin
      frame_o[DATA_W-1:0] = data_i;
      len_o = LEN_W'(DATA_W);
    end else begin
      frame_o[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
        if (i < nbits) frame_o[i+1] = dmask[i];
      end
      if (par_on) frame_o[nbits+1] = par_bit;
      len_o = LEN_W'(nbits + 2 + int'(par_on) + int'(mode_i.stop2));
    end
  end
endmodule

// File: rtl/sfx_shifter.sv
module sfx_shifter #(
  parameter int FRAME_W     = 12,
  parameter int LEN_W       = 4,
  parameter int ASYNC_TICKS = 16,
  parameter int SYNC_TICKS  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               pending,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               sync_i,
  output logic               load_o,
  output logic               txd_o,
  output logic               sclk_o,
  output logic               tend_o
);
  localparam int TMAX  = (ASYNC_TICKS > SYNC_TICKS) ? ASYNC_TICKS : SYNC_TICKS;
  localparam int CNT_W = (TMAX > 1) ? $clog2(TMAX) : 1;
  localparam int HALF  = SYNC_TICKS / 2;

  logic               busy_q, busy_n;
  logic               sync_q, sync_n;
  logic [FRAME_W-1:0] sh_q, sh_n;
  logic [LEN_W-1:0]   left_q, left_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               txd_q, sclk_q, tend_q, tend_n;
  logic [CNT_W-1:0]   tpb_last;
  logic               bit_done, frame_done, load;

  assign tpb_last   = sync_q ? CNT_W'(SYNC_TICKS - 1) : CNT_W'(ASYNC_TICKS - 1);
  assign bit_done   = busy_q & tick & (cnt_q == tpb_last);
  assign frame_done = bit_done & (left_q == LEN_W'(1));
  assign load       = pending & (~busy_q | frame_done);

  always_comb begin
    busy_n = busy_q;
    sync_n = sync_q;
    sh_n   = sh_q;
    left_n = left_q;
    cnt_n  = cnt_q;
    tend_n = tend_q;
    if (load) begin
      busy_n = 1'b1;
      sync_n = sync_i;
      sh_n   = frame_i;
      left_n = len_i;
      cnt_n  = '0;
      tend_n = 1'b0;
    end else if (frame_done) begin
      busy_n = 1'b0;
      cnt_n  = '0;
      tend_n = 1'b1;
    end else if (bit_done) begin
      sh_n   = sh_q >> 1;
      left_n = left_q - LEN_W'(1);
      cnt_n  = '0;
    end else if (busy_q && tick) begin
      cnt_n = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      sync_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
      txd_q  <= 1'b1;
      sclk_q <= 1'b1;
      tend_q <= 1'b1;
    end else begin
      busy_q <= busy_n;
      sync_q <= sync_n;
      sh_q   <= sh_n;
      left_q <= left_n;
      cnt_q  <= cnt_n;
      txd_q  <= busy_n ? sh_n[0] : 1'b1;
      sclk_q <= ~(busy_n & sync_n & (cnt_n < CNT_W'(HALF)));
      tend_q <= tend_n;
    end
  end

  assign load_o = load;
  assign txd_o  = txd_q;
  assign sclk_o = sclk_q;
  assign tend_o = tend_q;

  // R1: idle line is high on both outputs
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (txd_q && sclk_q));
  // R9: the end flag never shows while a frame runs
  a_r9_tend_only_idle: assert property (@(posedge clk) disable iff (rst)
    tend_q |-> !busy_q);
  // R9: a pending byte at frame end starts the next frame at once
  a_r9_back_to_back: assert property (@(posedge clk) disable iff (rst)
    (frame_done && pending) |=> busy_q);
  // R8: the serial clock pulses only during synchronous frames
  a_r8_sclk_sync_only: assert property (@(posedge clk) disable iff (rst)
    !sclk_q |-> (busy_q && sync_q));
  // R12: no line change without a tick during a frame
  a_r12_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !tick) |=> $stable(txd_q));
endmodule

// File: rtl/sfx_tx.sv
module sfx_tx
  import sfx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ASYNC_TICKS = 16,
  parameter int SYNC_TICKS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [DATA_W-1:0] mode_wdata,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_wdata,
  input  logic              tick,
  output logic              txd,
  output logic              sclk,
  output logic              dre,
  output logic              tend
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  mode_t               mode;
  logic [DATA_W-1:0]   held;
  logic                full;
  logic                load;
  logic [FRAME_W-1:0]  frame;
  logic [LEN_W-1:0]    len;

  sfx_mode_reg #(.REG_W(DATA_W)) u_mode (
    .clk    (clk),
    .rst    (rst),
    .wr     (mode_wr),
    .wdata  (mode_wdata),
    .mode_o (mode)
  );

  sfx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .wr     (data_wr),
    .wdata  (data_wdata),
    .take   (load),
    .data_o (held),
    .full_o (full),
    .dre_o  (dre)
  );

  sfx_frame_build #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_build (
    .data_i  (held),
    .mode_i  (mode),
    .frame_o (frame),
    .len_o   (len)
  );

  sfx_shifter #(
    .FRAME_W     (FRAME_W),
    .LEN_W       (LEN_W),
    .ASYNC_TICKS (ASYNC_TICKS),
    .SYNC_TICKS  (SYNC_TICKS)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .pending (full),
    .frame_i (frame),
    .len_i   (len),
    .sync_i  (mode.sync),
    .load_o  (load),
    .txd_o   (txd),
    .sclk_o  (sclk),
    .tend_o  (tend)
  );
endmodule

// File: tb/tb_sfx_tx.sv
module tb_sfx_tx;
  localparam int AT = 16;
  localparam int ST = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_wr = 1'b0, data_wr = 1'b0, tick = 1'b0;
  logic [7:0] mode_wdata = '0, data_wdata = '0;
  logic       txd, sclk, dre, tend;

  sfx_tx #(.DATA_W(8), .ASYNC_TICKS(AT), .SYNC_TICKS(ST)) dut (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .data_wr(data_wr), .data_wdata(data_wdata), .tick(tick),
    .txd(txd), .sclk(sclk), .dre(dre), .tend(tend)
  );

  always #10 clk = ~clk;  // 50 MHz

  int    checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  bit    compare_on = 0;
  int    tick_mode = 0, tdiv = 0;

  // Reference model state
  bit       m_full, m_busy, m_sync, m_tend;
  bit [7:0] m_hold, m_mode;
  bit       bq[$];
  int       m_cnt;
  bit       e_txd = 1, e_sclk = 1, e_dre = 1, e_tend = 1;

  task automatic build(input bit [7:0] md, input bit [7:0] d);
    bq.delete();
    if (md[7]) begin
      for (int i = 0; i < 8; i++) bq.push_back(d[i]);
    end else begin
      int nd; bit par; bit p;
      nd = md[6] ? 7 : 8;
      bq.push_back(1'b0);
      for (int i = 0; i < nd; i++) bq.push_back(d[i]);
      par = md[5] && !md[2];
      if (par) begin
        p = md[4];
        for (int i = 0; i < nd; i++) p ^= d[i];
        bq.push_back(p);
      end
      bq.push_back(1'b1);
      if (md[3]) bq.push_back(1'b1);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_full = 0; m_busy = 0; m_sync = 0; m_tend = 1;
      m_hold = '0; m_mode = '0; m_cnt = 0; bq.delete();
    end else begin
      bit ended; ended = 0;
      if (m_busy && tick) begin
        if (m_cnt == (m_sync ? ST : AT) - 1) begin
          void'(bq.pop_front());
          m_cnt = 0;
          if (bq.size() == 0) begin m_busy = 0; ended = 1; end
        end else m_cnt++;
      end
      if (!m_busy && m_full) begin
        build(m_mode, m_hold);
        m_sync = m_mode[7]; m_busy = 1; m_cnt = 0; m_full = 0; m_tend = 0;
      end else if (ended) m_tend = 1;
      if (mode_wr) m_mode = mode_wdata;
      if (data_wr) begin m_hold = data_wdata; m_full = 1; end
    end
    e_txd  = m_busy ? bq[0] : 1'b1;
    e_sclk = !(m_busy && m_sync && m_cnt < ST / 2);
    e_dre  = !m_full;
    e_tend = m_tend;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (compare_on) begin
      checks++;
      if (txd !== e_txd || sclk !== e_sclk || dre !== e_dre || tend !== e_tend) begin
        errors++;
        $display("FAIL %s t=%0t txd/sclk/dre/tend actual %b%b%b%b expected %b%b%b%b",
                 cur_req, $time, txd, sclk, dre, tend, e_txd, e_sclk, e_dre, e_tend);
      end
    end
    if (tick_mode == 0) tick = 1'b1;
    else begin tick = (tdiv == 0); tdiv = (tdiv + 1) % 3; end
  end

  task automatic cyc(); @(negedge clk); endtask
  task automatic wr_mode(input bit [7:0] v);
    mode_wr = 1; mode_wdata = v; cyc(); mode_wr = 0;
  endtask
  task automatic wr_data(input bit [7:0] v);
    data_wr = 1; data_wdata = v; cyc(); data_wr = 0;
  endtask
  task automatic chk(input string req, input bit ok, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual txd=%b sclk=%b dre=%b tend=%b", req, what, txd, sclk, dre, tend);
    end
  endtask
  task automatic wait_idle(input string req);
    while (!(m_tend && !m_full)) cyc();
    cyc();
    chk(req, tend === 1'b1 && dre === 1'b1 && txd === 1'b1, "expected idle tend=1 dre=1 txd=1");
  endtask
  task automatic send(input string req, input bit [7:0] md, input bit [7:0] d);
    cur_req = req; wr_mode(md); wr_data(d); wait_idle(req);
  endtask

  initial begin
    cyc(); cyc();
    // R1: reset state
    chk("R1", txd === 1 && sclk === 1 && dre === 1 && tend === 1, "expected reset 1111");
    rst = 0; cyc();
    compare_on = 1;
    cur_req = "R2"; wr_data(8'h00); cyc();
    chk("R2", dre === 1'b1 && tend === 1'b0, "expected dre=1 tend=0 after load");
    wait_idle("R2");
    send("R3", 8'h00, 8'hA5);                // 8N1 LSB first
    send("R7", 8'h08, 8'h3C);                // two stop bits
    send("R5", 8'h20, 8'h07);                // even parity
    send("R5", 8'h30, 8'h07);                // odd parity
    send("R5", 8'h30, 8'h00);
    send("R4", 8'h40, 8'h80);                // bit 7 dropped
    send("R4", 8'h60, 8'hFF);                // 7 bits, even parity
    send("R6", 8'h24, 8'h01);                // multiprocessor, no parity
    send("R6", 8'h3C, 8'hFE);
    send("R8", 8'hF8, 8'h96);                // sync ignores chr/par/stop
    send("R8", 8'h80, 8'h01);
    // R9: byte pending at frame end, back-to-back frames
    cur_req = "R9"; wr_mode(8'h28); wr_data(8'h5A); cyc();
    chk("R9", tend === 1'b0, "expected tend=0 during frame");
    wr_data(8'hC3);
    chk("R9", dre === 1'b0, "expected dre=0 with byte pending");
    wait_idle("R9");
    // R10: write in the load cycle
    cur_req = "R10"; wr_mode(8'h00); wr_data(8'h11); wr_data(8'hEE);
    chk("R10", dre === 1'b0, "expected dre=0 after colliding write");
    wait_idle("R10");
    // R11: mode rewritten mid-frame
    cur_req = "R11"; wr_mode(8'h00); wr_data(8'h69);
    repeat (40) cyc();
    wr_mode(8'hB8); wr_data(8'h3E);
    wait_idle("R11");
    // R12: sparse ticks
    cur_req = "R12"; tick_mode = 1;
    send("R12", 8'h38, 8'h5A);
    send("R12", 8'h80, 8'hC6);
    compare_on = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule